// File: doc/BRIEF.md
# Pooled Supply Power Budget Manager

This block keeps the power budget of a switch whose supplies sit in a few hot-swap slots. Each slot reports whether a unit is fitted, whether that unit is healthy, and a code for its rated output. The block adds up the healthy units into a pool. In redundant mode it holds back the largest unit as a reserve. It then takes a fixed system reservation off the top, and what is left is the share available to powered devices.

Per-port requests from the PoE controller are granted against that share or denied. Releases return a port's power to the pool. When a supply fails or is pulled, existing grants stay in place. If the allocation no longer fits, the block raises an alarm and pulses a shed request, and a separate agent decides which ports to shed.

The budget is recomputed in the clock edge after any change in slot state or mode. A request that arrives in that same cycle is held off rather than judged against a stale figure.

Top module: `poe_budget_mgr`

## Requirements
- R1: A slot contributes capacity only when its present and healthy bits are both 1. Its 2-bit kind code (slot s at bits 2s+1:2s) maps 0 to 500 W, 1 to 850 W, 2 to 1600 W and 3 to 0 W. A 0 W unit does not count as a contributing supply.
- R2: With `redundant` = 0, the usable budget is the sum of all contributing capacities.
- R3: With `redundant` = 1 and at least two contributing supplies, the usable budget is the sum minus the largest contributing capacity. With fewer than two contributing supplies, nothing is subtracted.
- R4: The PoE share is the usable budget minus SYS_RES (default 400 W), floored at 0. The remaining output is the PoE share minus the total allocation, floored at 0.
- R5: The usable, share and remaining outputs reflect a change of slot state or mode one clock edge after the change is presented, and not before.
- R6: Every request gets a response (`rsp_valid`) in the cycle after the edge that sampled it. A non-release request sampled at an edge where slot state or mode differs from the previous edge's sample is denied with `rsp_hold` = 1.
- R7: A non-release request is granted only if its wattage is at most 90 and the total with the port's allocation replaced by the new value does not exceed the PoE share. On grant, the port's allocation becomes the requested value.
- R8: A denied request leaves every port allocation, and so the total allocation, unchanged.
- R9: A release (`req_release` = 1) sets the port's allocation to 0 and is always granted, including during a hold.
- R10: Loss of capacity never removes grants. `over_alarm` is high whenever the total allocation exceeds the PoE share. `shed_req` is a one-cycle pulse in the cycle after `over_alarm` rises.
- R11: While reset is asserted, all outputs and allocations are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psu_present | input | NSLOT | Unit fitted, one bit per slot |
| psu_ok | input | NSLOT | Unit output healthy, one bit per slot |
| psu_kind | input | 2*NSLOT | Rated-capacity code per slot |
| redundant | input | 1 | 1 = hold largest unit in reserve, 0 = pool everything |
| req_valid | input | 1 | Request strobe |
| req_release | input | 1 | 1 = release the port, 0 = set its allocation |
| req_port | input | $clog2(NPORT) | Port index |
| req_watts | input | RW | Requested watts |
| rsp_valid | output | 1 | Response to last cycle's request |
| rsp_grant | output | 1 | Request granted |
| rsp_hold | output | 1 | Request denied because the budget was being recomputed |
| usable_w | output | PW | Usable budget in watts |
| poe_share_w | output | PW | Share available to powered devices |
| alloc_w | output | PW | Total granted watts |
| remain_w | output | PW | Share not yet granted |
| over_alarm | output | 1 | Allocation exceeds share |
| shed_req | output | 1 | One-cycle pulse asking for load shedding |

## Verification
The bench targets a redundant pool losing its biggest unit while ports are fully allocated. A design that dropped grants there would show a falling allocation, and one without the alarm would let new grants through. It checks a lone supply in redundant mode, where a design that always subtracts the largest unit would report zero budget. It also checks requests landing in the same cycle as a mode flip, where a design without the hold would grant against the old, larger share. Resizing a port that already holds power is covered as well: a design that adds instead of replacing would deny a request that fits. Random slot churn, with a behavioural model compared every cycle, covers the mixes in between.

// File: rtl/poe_budget_mgr.sv
module poe_budget_mgr #(
  parameter int NSLOT    = 3,
  parameter int NPORT    = 8,
  parameter int PW       = 13,
  parameter int RW       = 7,
  parameter int SYS_RES  = 400,
  parameter int PORT_MAX = 90
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSLOT-1:0]         psu_present,
  input  logic [NSLOT-1:0]         psu_ok,
  input  logic [2*NSLOT-1:0]       psu_kind,
  input  logic                     redundant,
  input  logic                     req_valid,
  input  logic                     req_release,
  input  logic [$clog2(NPORT)-1:0] req_port,
  input  logic [RW-1:0]            req_watts,
  output logic                     rsp_valid,
  output logic                     rsp_grant,
  output logic                     rsp_hold,
  output logic [PW-1:0]            usable_w,
  output logic [PW-1:0]            poe_share_w,
  output logic [PW-1:0]            alloc_w,
  output logic [PW-1:0]            remain_w,
  output logic                     over_alarm,
  output logic                     shed_req
);

  localparam int CFGW = 4*NSLOT + 1;
  localparam int CNTW = $clog2(NSLOT+1);

  function automatic logic [PW-1:0] unit_w(input logic [1:0] k);
    case (k)
      2'd0:    return PW'(500);
      2'd1:    return PW'(850);
      2'd2:    return PW'(1600);
      default: return '0;
    endcase
  endfunction

  logic [CFGW-1:0] cfg, cfg_q;
  logic [PW-1:0]   pool, big, reserve_c, usable_c, share_c;
  logic [CNTW-1:0] live;
  logic [PW-1:0]   usable_q, share_q, alloc_tot;
  logic [RW-1:0]   alloc [NPORT];
  logic [PW:0]     cand;
  logic            chg, fits, cap_ok, over_c, over_q, shed_q, rel_q;

  assign cfg = {redundant, psu_kind, psu_ok, psu_present};
  assign chg = cfg != cfg_q;

  always_comb begin
    logic [PW-1:0] c;
    pool = '0;
    big  = '0;
    live = '0;
    for (int s = 0; s < NSLOT; s++) begin
      c = (psu_present[s] && psu_ok[s]) ? unit_w(psu_kind[2*s +: 2]) : '0;
      pool = pool + c;
      if (c > big) big = c;
      if (c != '0) live = live + CNTW'(1);
    end
  end

  assign reserve_c = (redundant && live >= CNTW'(2)) ? big : '0;
  assign usable_c  = pool - reserve_c;
  assign share_c   = (usable_c > PW'(SYS_RES)) ? usable_c - PW'(SYS_RES) : '0;

  always_comb begin
    alloc_tot = '0;
    for (int p = 0; p < NPORT; p++) alloc_tot = alloc_tot + PW'(alloc[p]);
  end

  assign cand   = {1'b0, alloc_tot} - (PW+1)'(alloc[req_port]) + (PW+1)'(req_watts);
  assign fits   = cand <= {1'b0, share_q};
  assign cap_ok = req_watts <= RW'(PORT_MAX);
  assign over_c = alloc_tot > share_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      usable_q  <= '0;
      share_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      rsp_hold  <= 1'b0;
      rel_q     <= 1'b0;
      over_q    <= 1'b0;
      shed_q    <= 1'b0;
      for (int p = 0; p < NPORT; p++) alloc[p] <= '0;
    end else begin
      cfg_q     <= cfg;
      usable_q  <= usable_c;
      share_q   <= share_c;
      rsp_valid <= req_valid;
      rsp_grant <= 1'b0;
      rsp_hold  <= 1'b0;
      rel_q     <= req_valid && req_release;
      if (req_valid) begin
        if (req_release) begin
          alloc[req_port] <= '0;
          rsp_grant       <= 1'b1;
        end else if (chg) begin
          rsp_hold <= 1'b1;
        end else if (cap_ok && fits) begin
          alloc[req_port] <= req_watts;
          rsp_grant       <= 1'b1;
        end
      end
      over_q <= over_c;
      shed_q <= over_c && !over_q;
    end
  end

  assign usable_w    = usable_q;
  assign poe_share_w = share_q;
  assign alloc_w     = alloc_tot;
  assign remain_w    = over_c ? '0 : share_q - alloc_tot;
  assign over_alarm  = over_c;
  assign shed_req    = shed_q;

  a_r6_hold_denies: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_release && (cfg != cfg_q) |=> rsp_hold && !rsp_grant);

  a_r7_grant_fits: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_grant && !rel_q |-> alloc_tot <= share_q);

  a_r8_deny_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_grant |-> $stable(alloc_tot));

  a_r9_release_acked: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_release |=> rsp_valid && rsp_grant);

  a_r10_shed_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    shed_req |=> !shed_req);

  a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_grant && rsp_hold));

  for (genvar p = 0; p < NPORT; p++) begin : g_cap
    a_r7_port_cap: assert property (@(posedge clk) disable iff (!rst_n)
      alloc[p] <= RW'(PORT_MAX));
  end

endmodule

// File: tb/sim_poe_budget_mgr.sv
module sim_poe_budget_mgr;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] pres = '0, ok = '0;
  logic [5:0] kind = '0;
  logic red = 1'b0, rv = 1'b0, rrel = 1'b0;
  logic [2:0] rport = '0;
  logic [6:0] rw = '0;
  logic rsp_valid, rsp_grant, rsp_hold, over_alarm, shed_req;
  logic [12:0] usable_w, poe_share_w, alloc_w, remain_w;

  always #(CLK_NS/2) clk = ~clk;

  poe_budget_mgr u0 (
    .clk(clk), .rst_n(rst_n), .psu_present(pres), .psu_ok(ok), .psu_kind(kind),
    .redundant(red), .req_valid(rv), .req_release(rrel), .req_port(rport),
    .req_watts(rw), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_hold(rsp_hold),
    .usable_w(usable_w), .poe_share_w(poe_share_w), .alloc_w(alloc_w),
    .remain_w(remain_w), .over_alarm(over_alarm), .shed_req(shed_req));

  int vecs = 0, errs = 0;
  bit done = 0;

  int m_cfg = 0, m_usable = 0, m_share = 0;
  int m_alloc [8];
  bit m_rv = 0, m_rg = 0, m_rh = 0, m_over = 0, m_shed = 0;

  function automatic int capw(int k);
    case (k)
      0: return 500;
      1: return 850;
      2: return 1600;
      default: return 0;
    endcase
  endfunction

  function automatic int mtot();
    int t = 0;
    for (int p = 0; p < 8; p++) t += m_alloc[p];
    return t;
  endfunction

  task automatic model_step();
    int pool = 0, big = 0, live = 0, us, sh, cfg, tot;
    bit chg, over_c;
    if (!rst_n) begin
      m_cfg = 0; m_usable = 0; m_share = 0;
      m_rv = 0; m_rg = 0; m_rh = 0; m_over = 0; m_shed = 0;
      for (int p = 0; p < 8; p++) m_alloc[p] = 0;
      return;
    end
    for (int s = 0; s < 3; s++) begin
      int c = (pres[s] && ok[s]) ? capw(int'(kind[2*s +: 2])) : 0;
      pool += c;
      if (c > big) big = c;
      if (c != 0) live++;
    end
    us  = pool - ((red && live >= 2) ? big : 0);
    sh  = (us > 400) ? us - 400 : 0;
    cfg = int'({red, kind, ok, pres});
    chg = cfg != m_cfg;
    tot = mtot();
    over_c = tot > m_share;
    m_rv = rv; m_rg = 0; m_rh = 0;
    if (rv) begin
      if (rrel) begin
        m_alloc[rport] = 0; m_rg = 1;
      end else if (chg) begin
        m_rh = 1;
      end else if (rw <= 90 && tot - m_alloc[rport] + int'(rw) <= m_share) begin
        m_alloc[rport] = int'(rw); m_rg = 1;
      end
    end
    m_shed = over_c && !m_over;
    m_over = over_c;
    m_usable = us; m_share = sh; m_cfg = cfg;
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int tot = mtot();
    chk("R2/R3", "usable_w", int'(usable_w), m_usable);
    chk("R4", "poe_share_w", int'(poe_share_w), m_share);
    chk("R7", "alloc_w", int'(alloc_w), tot);
    chk("R4", "remain_w", int'(remain_w), (m_share > tot) ? m_share - tot : 0);
    chk("R6", "rsp_valid", int'(rsp_valid), int'(m_rv));
    chk("R7", "rsp_grant", int'(rsp_grant), int'(m_rg));
    chk("R6", "rsp_hold", int'(rsp_hold), int'(m_rh));
    chk("R10", "over_alarm", int'(over_alarm), int'(tot > m_share));
    chk("R10", "shed_req", int'(shed_req), int'(m_shed));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic req(int port, int w, bit rel);
    rv = 1'b1; rport = 3'(port); rw = 7'(w); rrel = rel;
    cyc();
    rv = 1'b0; rrel = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    cyc(); cyc();
    chk("R11", "usable in reset", int'(usable_w), 0);
    chk("R11", "alloc in reset", int'(alloc_w), 0);
    chk("R11", "flags in reset", int'({rsp_valid, rsp_grant, over_alarm, shed_req}), 0);
    rst_n = 1'b1;
    cyc();

    pres = 3'b111; ok = 3'b111; kind = {2'd2, 2'd1, 2'd0}; red = 1'b0;
    #1 chk("R5", "usable before edge", int'(usable_w), 0);
    cyc();
    chk("R2", "shared pool 500+850+1600", int'(usable_w), 2950);
    chk("R4", "share 2950-400", int'(poe_share_w), 2550);

    req(0, 90, 0);
    chk("R7", "90 W grant", int'(rsp_grant), 1);
    req(1, 91, 0);
    chk("R7", "91 W denied", int'(rsp_grant), 0);
    chk("R8", "alloc after deny", int'(alloc_w), 90);

    red = 1'b1;
    req(2, 30, 0);
    chk("R6", "hold during recompute", int'(rsp_hold), 1);
    chk("R6", "no grant during hold", int'(rsp_grant), 0);
    chk("R3", "redundant 2950-1600", int'(usable_w), 1350);

    for (int p = 1; p < 8; p++) req(p, 90, 0);
    chk("R7", "eight ports full", int'(alloc_w), 720);
    chk("R4", "remain 950-720", int'(remain_w), 230);
    req(0, 60, 0);
    chk("R7", "resize replaces", int'(alloc_w), 690);

    ok = 3'b011;
    cyc();
    chk("R3", "after 1600 fails", int'(usable_w), 500);
    chk("R10", "grants retained", int'(alloc_w), 690);
    chk("R10", "alarm raised", int'(over_alarm), 1);
    chk("R4", "remain floored", int'(remain_w), 0);
    cyc();
    chk("R10", "shed pulse", int'(shed_req), 1);
    cyc();
    chk("R10", "shed one cycle", int'(shed_req), 0);
    req(1, 10, 0);
    chk("R8", "shrink still over denied", int'(alloc_w), 690);
    req(3, 0, 1);
    chk("R9", "release granted", int'(rsp_grant), 1);
    chk("R9", "release frees", int'(alloc_w), 600);

    pres = 3'b010; ok = 3'b111;
    cyc();
    chk("R3", "lone 850 unreserved", int'(usable_w), 850);
    pres = 3'b001; kind = {2'd2, 2'd1, 2'd3};
    cyc();
    chk("R1", "code 3 is 0 W", int'(usable_w), 0);
    chk("R4", "share floored", int'(poe_share_w), 0);
    kind = {2'd2, 2'd1, 2'd0};
    cyc();
    chk("R1", "500 W unit", int'(usable_w), 500);
    red = 1'b0;
    req(4, 0, 1);
    chk("R9", "release during hold", int'(rsp_grant), 1);
    chk("R9", "no hold flag on release", int'(rsp_hold), 0);

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 7) == 0) begin
        pres = 3'($urandom); ok = 3'($urandom | $urandom); kind = 6'($urandom);
      end
      if ($urandom_range(0, 15) == 0) red = ~red;
      rv = ($urandom_range(0, 2) != 0);
      rrel = ($urandom_range(0, 4) == 0);
      rport = 3'($urandom);
      rw = 7'($urandom_range(0, 100));
      cyc();
    end
    rv = 1'b0;
    cyc();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule